// File: doc/BRIEF.md
# Five-Level Adiabatic Switch Sequencer Array

This block drives the switch controls of a row of ultrasound transmit channels that use stepwise (adiabatic) charging. Each channel owns five one-hot switch controls, one per supply level: ground, three intermediate levels and the top supply. Once per ultrasound period the channel climbs from ground through the three intermediate levels to the top supply, and then descends through the same levels back to ground. Charge that the load returns on the way down is handed to the intermediate rails, where another channel can take it up again.

A delay generator outside this block gives each channel its own start strobe. Each intermediate level lasts a fixed dwell of one clock (half of the inter-element delay step at the intended clock). So when no two channels start in the same cycle, every intermediate rail carries at most one rising and at most one falling channel in any cycle. The rails can then swap charge between channels and need no storage capacitor. An enable input stops new periods and leaves every channel parked on ground.

Top module: `adb_seq_array`

## Requirements
- R1: While rst_ni is low every switch control is 0. From the first clock edge after reset is released, each channel selects ground (bit 0 of its group) until it accepts a start.
- R2: After the first clock edge out of reset, each channel's five-bit group sw_o[5*c +: 5] has exactly one bit set. Bit j selects level j: 0 is ground, 1 to 3 are the intermediate levels in rising order, 4 is the top supply.
- R3: A start accepted at a clock edge makes the group show level 1 from that edge. The group then shows levels 2 and 3, one cycle each (MID_CYC), followed by level 4 for HI_CYC = 13 cycles.
- R4: After the top plateau the group shows levels 3, 2 and 1, one cycle each, then level 0. The full period is 32 cycles at the defaults.
- R5: Between consecutive cycles a channel's selected level changes by at most one step.
- R6: A start strobe that is sampled while the channel shows any level other than 0 is ignored. The running period continues unchanged.
- R7: While en_i is low no start is accepted. A period already in progress runs to ground, and the channel then stays at level 0.
- R8: After its period ends with no new start, a channel holds level 0. A start that arrives while the channel is at level 0, including the low plateau of a running period, restarts the sequence at once.
- R9: When accepted starts fall in distinct cycles, no intermediate level is entered by more than one rising channel or more than one falling channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; when low, no new period starts |
| start_i | input | N_CH | Per-channel start strobe from the delay generator |
| sw_o | output | 5*N_CH | One-hot switch controls, five bits per channel, bit j selects level j |

## Verification
The hardest situation to reach from the ports is a crowded array. In that case several channels are rising and falling through the intermediate rails together, and restarts land inside low plateaus and collide with ignored strobes. Long random runs reach it: in a cycle they strobe at most one randomly chosen channel and now and then drop the enable. This keeps the starts distinct while many periods overlap. Directed runs add strobes in the middle of a period, strobes while disabled, and restarts in the low plateau.

// File: rtl/adb_pkg.sv
package adb_pkg;
  localparam int unsigned N_LVL = 5;
  localparam int unsigned N_MID = 3;
  localparam int unsigned TOP_LVL = N_LVL - 1;

  typedef logic [$clog2(N_LVL)-1:0] lvl_t;
  typedef logic [N_LVL-1:0]         sw_t;

  function automatic sw_t lvl_onehot(lvl_t l);
    sw_t s;
    s = '0;
    s[l] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/adb_phase_ctr.sv
module adb_phase_ctr #(
  parameter int unsigned PERIOD = 32,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          at_gnd_i,
  output logic          busy_d_o,
  output logic [CW-1:0] cnt_d_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = en_i && start_i && at_gnd_i;

  always_comb begin
    busy_d_o = busy_q;
    cnt_d_o  = cnt_q;
    if (accept) begin
      busy_d_o = 1'b1;
      cnt_d_o  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(PERIOD - 1)) begin
        busy_d_o = 1'b0;
        cnt_d_o  = '0;
      end else begin
        cnt_d_o = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d_o;
      cnt_q  <= cnt_d_o;
    end
  end

  // R6
  strobe_off_gnd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !at_gnd_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R7
  idle_stays_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_q) |=> !busy_q);
endmodule

// File: rtl/adb_level_map.sv
module adb_level_map
  import adb_pkg::*;
#(
  parameter int unsigned MID_CYC = 1,
  parameter int unsigned HI_CYC  = 13,
  parameter int unsigned LO_CYC  = 13,
  localparam int unsigned RAMP   = N_MID * MID_CYC,
  localparam int unsigned PERIOD = 2 * RAMP + HI_CYC + LO_CYC,
  localparam int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  output lvl_t          lvl_o,
  output logic          rise_o,
  output logic          fall_o
);
  int unsigned pos;

  always_comb begin
    pos    = 32'(cnt_i);
    lvl_o  = '0;
    rise_o = 1'b0;
    fall_o = 1'b0;
    if (busy_i) begin
      if (pos < RAMP) begin
        lvl_o  = lvl_t'(pos / MID_CYC + 1);
        rise_o = 1'b1;
      end else if (pos < RAMP + HI_CYC) begin
        lvl_o = lvl_t'(TOP_LVL);
      end else if (pos < 2 * RAMP + HI_CYC) begin
        lvl_o  = lvl_t'(N_MID - (pos - RAMP - HI_CYC) / MID_CYC);
        fall_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adb_switch_reg.sv
module adb_switch_reg
  import adb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t lvl_d_i,
  input  logic rise_d_i,
  input  logic fall_d_i,
  output sw_t  sw_o,
  output lvl_t lvl_o,
  output logic rise_o,
  output logic fall_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_o    <= '0;
      lvl_o   <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      sw_o    <= lvl_onehot(lvl_d_i);
      lvl_o   <= lvl_d_i;
      rise_o  <= rise_d_i;
      fall_o  <= fall_d_i;
      valid_o <= 1'b1;
    end
  end

  // R2
  one_switch_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(sw_o));

  // R5
  adjacent_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |->
      (lvl_o == $past(lvl_o) || lvl_o == $past(lvl_o) + 1'b1 || lvl_o + 1'b1 == $past(lvl_o)));

  // R1
  always_comb begin
    if (!rst_ni) reset_all_off_chk: assert (sw_o == '0);
  end
endmodule

// File: rtl/adb_seq_array.sv
module adb_seq_array
  import adb_pkg::*;
#(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned MID_CYC = 1,
  parameter int unsigned HI_CYC  = 13,
  parameter int unsigned LO_CYC  = 13,
  localparam int unsigned PERIOD = 2 * N_MID * MID_CYC + HI_CYC + LO_CYC,
  localparam int unsigned CW     = $clog2(PERIOD),
  localparam int unsigned NW     = $clog2(N_CH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [N_CH-1:0]     start_i,
  output logic [N_LVL*N_CH-1:0] sw_o
);
  lvl_t            lvl_q [N_CH];
  logic [N_CH-1:0] rise_q, fall_q, valid_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic          busy_d;
    logic [CW-1:0] cnt_d;
    lvl_t          lvl_d;
    logic          rise_d, fall_d, at_gnd;
    sw_t           sw;

    assign at_gnd = valid_q[c] && (lvl_q[c] == '0);

    adb_phase_ctr #(.PERIOD(PERIOD)) i_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .start_i  (start_i[c]),
      .at_gnd_i (at_gnd),
      .busy_d_o (busy_d),
      .cnt_d_o  (cnt_d)
    );

    adb_level_map #(.MID_CYC(MID_CYC), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) i_map (
      .busy_i (busy_d),
      .cnt_i  (cnt_d),
      .lvl_o  (lvl_d),
      .rise_o (rise_d),
      .fall_o (fall_d)
    );

    adb_switch_reg i_sw (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_d_i  (lvl_d),
      .rise_d_i (rise_d),
      .fall_d_i (fall_d),
      .sw_o     (sw),
      .lvl_o    (lvl_q[c]),
      .rise_o   (rise_q[c]),
      .fall_o   (fall_q[c]),
      .valid_o  (valid_q[c])
    );

    assign sw_o[N_LVL*c +: N_LVL] = sw;
  end

  // array-wide rail occupancy, one pair of counters per intermediate level
  for (genvar m = 1; m <= N_MID; m++) begin : g_rail
    logic [NW-1:0] n_up, n_dn;
    always_comb begin
      n_up = '0;
      n_dn = '0;
      for (int c = 0; c < N_CH; c++) begin
        if (rise_q[c] && lvl_q[c] == lvl_t'(m)) n_up = n_up + 1'b1;
        if (fall_q[c] && lvl_q[c] == lvl_t'(m)) n_dn = n_dn + 1'b1;
      end
    end

    // R9
    rail_single_riser_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_up <= NW'(1));
    // R9
    rail_single_faller_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_dn <= NW'(1));
  end
endmodule

// File: tb/test_adb_seq_array.sv
module test_adb_seq_array;
  localparam int N_CH = 16;
  localparam int NL = 5;
  localparam int PERIOD = 32;
  localparam time TCK = 8ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [N_CH-1:0] start_i = '0;
  logic [NL*N_CH-1:0] sw_o;

  int n_chk = 0, n_fail = 0;
  int pos [N_CH];
  int prev_lvl [N_CH];
  bit first_cycle;

  always #(TCK/2) clk = ~clk;

  adb_seq_array #(.N_CH(N_CH)) i_adb_seq_array (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .start_i(start_i), .sw_o(sw_o)
  );

  function automatic int exp_lvl(int p);
    if (p < 0) return 0;
    if (p < 3) return p + 1;
    if (p < 16) return 4;
    if (p < 19) return 3 - (p - 16);
    return 0;
  endfunction

  function automatic string pos_tag(int p);
    if (p < 0) return "R8";
    if (p < 16) return "R3";
    return "R4";
  endfunction

  task automatic chk(bit ok, string tag, int c, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, c, act, exp);
    end
  endtask

  // compare at negedge, then drive the inputs and advance the model past the next edge
  task automatic cycle(string tag, logic en, logic [N_CH-1:0] st);
    int up [4], dn [4];
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin up[m] = 0; dn[m] = 0; end
    for (int c = 0; c < N_CH; c++) begin
      logic [NL-1:0] g;
      int act;
      string t;
      g = sw_o[NL*c +: NL];
      act = -1;
      for (int j = 0; j < NL; j++) if (g[j]) act = j;
      t = first_cycle ? "R1" : (tag != "" ? tag : pos_tag(pos[c]));
      chk($countones(g) == 1, "R2", c, $countones(g), 1);
      chk(act == exp_lvl(pos[c]), t, c, act, exp_lvl(pos[c]));
      if (!first_cycle) begin
        int d;
        d = act - prev_lvl[c];
        chk(d >= -1 && d <= 1, "R5", c, act, prev_lvl[c]);
        if (act >= 1 && act <= 3 && d == 1) up[act]++;
        if (act >= 1 && act <= 3 && d == -1) dn[act]++;
      end
      prev_lvl[c] = act;
    end
    for (int m = 1; m <= 3; m++) begin
      chk(up[m] <= 1, "R9", m, up[m], 1);
      chk(dn[m] <= 1, "R9", m, dn[m], 1);
    end
    first_cycle = 1'b0;
    en_i = en;
    start_i = st;
    for (int c = 0; c < N_CH; c++) begin
      if (en && st[c] && exp_lvl(pos[c]) == 0) pos[c] = 0;
      else if (pos[c] >= 0) begin
        pos[c]++;
        if (pos[c] == PERIOD) pos[c] = -1;
      end
    end
  endtask

  function automatic logic [N_CH-1:0] one(int c);
    logic [N_CH-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < N_CH; c++) begin pos[c] = -1; prev_lvl[c] = 0; end
    // R1: all off while in reset
    repeat (3) @(negedge clk);
    chk(sw_o == '0, "R1", 0, int'(sw_o != '0), 0);
    rst_ni = 1'b1;
    @(posedge clk);
    first_cycle = 1'b1;
    cycle("", 1'b1, '0);

    // R3 R4: single full period on ch0
    cycle("", 1'b1, one(0));
    repeat (36) cycle("", 1'b1, '0);

    // R6: strobe mid-period
    cycle("", 1'b1, one(1));
    repeat (5) cycle("", 1'b1, '0);
    cycle("R6", 1'b1, one(1));
    cycle("R6", 1'b1, one(1));
    repeat (30) cycle("", 1'b1, '0);

    // R7: disable during a period, keep strobing
    cycle("", 1'b1, one(2));
    repeat (4) cycle("", 1'b1, '0);
    repeat (40) cycle("R7", 1'b0, one(2));

    // R8: restart inside low plateau, then idle hold
    cycle("", 1'b1, one(3));
    repeat (24) cycle("", 1'b1, '0);
    cycle("R8", 1'b1, one(3));
    repeat (40) cycle("R8", 1'b1, '0);

    // random: at most one strobe per cycle keeps starts distinct (R9)
    for (int i = 0; i < 4000; i++) begin
      logic en;
      logic [N_CH-1:0] st;
      en = ($urandom_range(0, 19) != 0);
      st = ($urandom_range(0, 2) == 0) ? one($urandom_range(0, N_CH - 1)) : '0;
      cycle("", en, st);
    end
    repeat (40) cycle("", 1'b1, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule